// File: doc/BRIEF.md
# Rounding Saturating Fixed-Point Multiplier

This block multiplies two signed 16-bit fixed-point numbers. Both operands carry the same number of fraction bits, set at compile time. The result comes back in that same format. The block first forms the exact product at double width. It then adds half of one result LSB, so that midpoint values round toward positive infinity. An arithmetic right shift restores the operand scaling. Finally the value is clamped into the 16-bit two's complement range, and a flag marks every result that was clamped.

Operands enter through a valid/ready handshake. A compile-time switch picks one of two variants:
- one registered output stage that stalls under backpressure;
- a purely combinational path, where valid and ready pass straight through.

The stored word is two's complement with the sign in the MSB. One LSB is worth 2^-Q, where Q is the fraction-bit count.

Top module: `fxmul_rs`

## Requirements
- R1: The product of the two operands is formed exactly at double width. For example, with Q=15, 0x7FFF × 0x7FFF gives 0x7FFE and 0x8000 × 0x7FFF gives 0x8001, with no wrap.
- R2: For Q>0, the constant 2^(Q-1) is added to the product before shifting, so midpoints round up. With Q=15: 0x0001×0x4000 gives 0x0001, 0xFFFF×0x4000 gives 0x0000, 0x0001×0x3FFF gives 0x0000, and 0x8000×0x0001 gives 0xFFFF.
- R3: The rounded product is shifted right arithmetically by Q bits. With Q=15: 0x4000×0x4000 gives 0x2000, 0xC000×0x4000 gives 0xE000, and 0x6000×0x6000 gives 0x4800.
- R4: A shifted value above 0x7FFF yields 0x7FFF. A shifted value below -0x8000 yields 0x8000. With Q=15, 0x8000×0x8000 yields 0x7FFF.
- R5: out_sat is 1 in exactly the cycles where a clamped result is presented with out_valid high, and 0 for results in range.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_y and out_sat stay unchanged.
- R7: In the registered variant, in_ready is 1 only when the output stage is empty or is being consumed in the same cycle. An operand pair offered while in_ready is 0 is not taken.
- R8: With Q=0, no rounding constant is added and the result is the clamped integer product. For example, 3×5 gives 0x000F, 0xFFFD×5 gives 0xFFF1, 0x0100×0x8000 gives 0x8000 with out_sat=1, and 0x7FFF×2 gives 0x7FFF with out_sat=1.
- R9: In the combinational variant, out_valid equals in_valid, in_ready equals out_ready, and the result appears in the same cycle as the operands.
- R10: After a synchronous reset, the registered variant presents out_valid=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take the operand pair this cycle |
| op_a | input | 16 | First operand, signed fixed-point |
| op_b | input | 16 | Second operand, signed fixed-point |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_y | output | 16 | Rounded, clamped product |
| out_sat | output | 1 | Result was clamped |

## Verification
Some properties are checked by the assertions on every cycle:
- the residue left by the shift stays within the half-LSB window, which covers the rounding direction;
- a clamped result is always one of the two extreme codes, and an unclamped result equals the shifted value;
- a stalled output holds steady;
- in_ready stays low under backpressure;
- the combinational variant passes the handshake straight through.

The bench scenarios show what no single-cycle property can:
- the exact values at the rounding midpoints and extreme operands, for Q=15 and Q=0;
- that an operand pair offered while stalled is taken only once the stage drains;
- the state right after reset.

// File: rtl/fxmul_pkg.sv
package fxmul_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned PROD_W = 2 * WORD_W;
    localparam int unsigned EXT_W  = PROD_W + 1;

    typedef logic signed [WORD_W-1:0] word_t;
    typedef logic signed [EXT_W-1:0]  ext_t;

    typedef struct packed {
        logic  sat;
        word_t y;
    } res_t;

    localparam word_t WORD_MAX = {1'b0, {(WORD_W-1){1'b1}}};
    localparam word_t WORD_MIN = {1'b1, {(WORD_W-1){1'b0}}};

    // Half of one result LSB expressed at product scale; zero when there are no fraction bits.
    function automatic ext_t half_lsb(int unsigned q);
        if (q == 0)
            return '0;
        return ext_t'(1) << (q - 1);
    endfunction
endpackage

// File: rtl/fxmul_core.sv
module fxmul_core
    import fxmul_pkg::*;
#(
    parameter int unsigned FRAC_BITS = 15
) (
    input  word_t a,
    input  word_t b,
    output ext_t  scaled
);
    localparam ext_t HALF = half_lsb(FRAC_BITS);

    ext_t prod_x;
    ext_t rounded;
    ext_t resid;

    always_comb begin
        prod_x  = ext_t'(a) * ext_t'(b);
        rounded = prod_x + HALF;
        scaled  = rounded >>> FRAC_BITS;
    end

    // Residue between exact product and rescaled result must sit in [-half, +half)
    always_comb begin
        resid = prod_x - (scaled <<< FRAC_BITS);
        if (FRAC_BITS == 0) begin
            p_round_window_r8: assert (resid == '0)
                else $error("residue nonzero with no fraction bits");
        end else begin
            p_round_window_r2: assert (resid >= -HALF && resid < HALF)
                else $error("rounding residue outside half-LSB window");
        end
    end
endmodule

// File: rtl/fxmul_clamp.sv
module fxmul_clamp
    import fxmul_pkg::*;
(
    input  ext_t v,
    output res_t r
);
    localparam ext_t EXT_MAX = ext_t'(WORD_MAX);
    localparam ext_t EXT_MIN = ext_t'(WORD_MIN);

    always_comb begin
        if (v > EXT_MAX) begin
            r.y   = WORD_MAX;
            r.sat = 1'b1;
        end else if (v < EXT_MIN) begin
            r.y   = WORD_MIN;
            r.sat = 1'b1;
        end else begin
            r.y   = word_t'(v);
            r.sat = 1'b0;
        end
    end

    always_comb begin
        p_clamp_extreme_r4: assert (!r.sat || r.y == WORD_MAX || r.y == WORD_MIN)
            else $error("clamped value is not an extreme code");
        p_no_clamp_exact_r1: assert (r.sat || ext_t'(r.y) == v)
            else $error("unclamped value differs from shifted value");
    end
endmodule

// File: rtl/fxmul_stage.sv
module fxmul_stage
    import fxmul_pkg::*;
#(
    parameter bit PIPE_STAGE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  res_t res_i,
    output logic out_valid,
    input  logic out_ready,
    output res_t res_o
);
    generate
        if (PIPE_STAGE) begin : g_reg
            logic vld_q;
            res_t data_q;

            assign in_ready  = !vld_q || out_ready;
            assign out_valid = vld_q;
            assign res_o     = data_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q  <= 1'b0;
                    data_q <= '0;
                end else if (in_valid && in_ready) begin
                    vld_q  <= 1'b1;
                    data_q <= res_i;
                end else if (out_ready) begin
                    vld_q  <= 1'b0;
                end
            end

            p_hold_r6: assert property (@(posedge clk) disable iff (rst)
                out_valid && !out_ready |=> out_valid && $stable(res_o))
                else $error("stalled result changed");

            p_backpressure_r7: assert property (@(posedge clk) disable iff (rst)
                out_valid && !out_ready |-> !in_ready)
                else $error("ready high while stage full and stalled");

            p_reset_empty_r10: assert property (@(posedge clk)
                rst |=> !out_valid)
                else $error("output valid after reset");
        end else begin : g_comb
            assign in_ready  = out_ready;
            assign out_valid = in_valid;
            assign res_o     = res_i;

            always_comb begin
                p_pass_through_r9: assert (out_valid == in_valid && in_ready == out_ready)
                    else $error("handshake not passed through");
            end
        end
    endgenerate
endmodule

// File: rtl/fxmul_rs.sv
module fxmul_rs
    import fxmul_pkg::*;
#(
    parameter int unsigned FRAC_BITS  = 15,
    parameter bit          PIPE_STAGE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [15:0] out_y,
    output logic        out_sat
);
    ext_t scaled;
    res_t res_c;
    res_t res_o;

    fxmul_core #(.FRAC_BITS(FRAC_BITS)) core_i (
        .a      (word_t'(op_a)),
        .b      (word_t'(op_b)),
        .scaled (scaled)
    );

    fxmul_clamp clamp_i (
        .v (scaled),
        .r (res_c)
    );

    fxmul_stage #(.PIPE_STAGE(PIPE_STAGE)) stage_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .res_i     (res_c),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .res_o     (res_o)
    );

    assign out_y   = res_o.y;
    assign out_sat = res_o.sat;

    p_sat_codes_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sat |-> out_y == 16'h7FFF || out_y == 16'h8000)
        else $error("sat flagged on a non-extreme result");
endmodule

// File: tb/fxmul_rs_tb_top.sv
module fxmul_rs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    localparam logic [15:0] VA [NVEC] = '{16'h4000, 16'hC000, 16'h0001, 16'hFFFF, 16'h0001, 16'h7FFF,
                                          16'h8000, 16'h8000, 16'h0000, 16'h6000, 16'hFFFF, 16'h8000};
    localparam logic [15:0] VB [NVEC] = '{16'h4000, 16'h4000, 16'h4000, 16'h4000, 16'h3FFF, 16'h7FFF,
                                          16'h8000, 16'h7FFF, 16'h1234, 16'h6000, 16'hFFFF, 16'h0001};
    localparam logic [15:0] VY [NVEC] = '{16'h2000, 16'hE000, 16'h0001, 16'h0000, 16'h0000, 16'h7FFE,
                                          16'h7FFF, 16'h8001, 16'h0000, 16'h4800, 16'h0000, 16'hFFFF};
    localparam logic        VS [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                          1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, out_ready = 1'b1;
    logic [15:0] op_a = '0, op_b = '0;
    logic in_ready, out_valid, out_sat;
    logic [15:0] out_y;

    logic z_in_valid = 1'b0, z_out_ready = 1'b1;
    logic [15:0] z_a = '0, z_b = '0;
    logic z_in_ready, z_out_valid, z_sat;
    logic [15:0] z_y;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxmul_rs #(.FRAC_BITS(15), .PIPE_STAGE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
        .out_y(out_y), .out_sat(out_sat)
    );

    fxmul_rs #(.FRAC_BITS(0), .PIPE_STAGE(1'b0)) dut_q0_i (
        .clk(clk), .rst(rst), .in_valid(z_in_valid), .in_ready(z_in_ready),
        .op_a(z_a), .op_b(z_b), .out_valid(z_out_valid), .out_ready(z_out_ready),
        .out_y(z_y), .out_sat(z_sat)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic z_case(string tag, logic [15:0] a, logic [15:0] b, logic [15:0] y, logic s);
        z_a = a; z_b = b; z_in_valid = 1'b1;
        #1;
        chk({tag, " y"}, {16'h0, z_y}, {16'h0, y});
        chk({tag, " sat"}, {31'h0, z_sat}, {31'h0, s});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 out_valid in reset", {31'h0, out_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 out_valid after reset", {31'h0, out_valid}, 32'h0);
        chk("R10 in_ready after reset", {31'h0, in_ready}, 32'h1);

        // Vector table, Q=15 (R1 R2 R3 R4 R5)
        for (int i = 0; i < NVEC; i++) begin
            op_a = VA[i]; op_b = VB[i]; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk($sformatf("R1/R2/R3/R4 vec%0d valid", i), {31'h0, out_valid}, 32'h1);
            chk($sformatf("R1/R2/R3/R4 vec%0d y", i), {16'h0, out_y}, {16'h0, VY[i]});
            chk($sformatf("R5 vec%0d sat", i), {31'h0, out_sat}, {31'h0, VS[i]});
        end
        @(negedge clk);
        chk("R10 idle drains", {31'h0, out_valid}, 32'h0);

        // Backpressure: R6 R7
        out_ready = 1'b0;
        op_a = 16'h8000; op_b = 16'h8000; in_valid = 1'b1;
        @(negedge clk);
        op_a = 16'h4000; op_b = 16'h4000;
        chk("R7 in_ready low when full and stalled", {31'h0, in_ready}, 32'h0);
        chk("R6 first result", {16'h0, out_y}, 32'h7FFF);
        @(negedge clk);
        @(negedge clk);
        chk("R6 valid held", {31'h0, out_valid}, 32'h1);
        chk("R6 y held", {16'h0, out_y}, 32'h7FFF);
        chk("R6 sat held", {31'h0, out_sat}, 32'h1);
        out_ready = 1'b1;
        #1;
        chk("R7 in_ready while consumed", {31'h0, in_ready}, 32'h1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 next result after drain", {16'h0, out_y}, 32'h2000);
        chk("R5 sat cleared", {31'h0, out_sat}, 32'h0);
        @(negedge clk);
        chk("R7 single take", {31'h0, out_valid}, 32'h0);

        // Q=0 combinational variant: R8 R9
        z_case("R8 3x5", 16'h0003, 16'h0005, 16'h000F, 1'b0);
        z_case("R8 -3x5", 16'hFFFD, 16'h0005, 16'hFFF1, 1'b0);
        z_case("R8 neg clamp", 16'h0100, 16'h8000, 16'h8000, 1'b1);
        z_case("R8 pos clamp", 16'h7FFF, 16'h0002, 16'h7FFF, 1'b1);
        z_case("R8 min x min", 16'h8000, 16'h8000, 16'h7FFF, 1'b1);
        z_case("R8 -1x-1", 16'hFFFF, 16'hFFFF, 16'h0001, 1'b0);
        chk("R9 valid passes", {31'h0, z_out_valid}, 32'h1);
        z_out_ready = 1'b0;
        #1;
        chk("R9 ready passes", {31'h0, z_in_ready}, 32'h0);
        z_in_valid = 1'b0;
        #1;
        chk("R9 valid low passes", {31'h0, z_out_valid}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule